// File: doc/BRIEF.md
# Snooping MOESI Line-State Controller

This block keeps the five-state coherence state (Invalid, Shared, Exclusive, Owned, Modified) of every line of one private cache that sits on a snooping bus. Requests from the local processor side (read, write, evict) and transactions observed on the bus from other caches (read miss, write miss, invalidate, write-update) both move a line's state. The block raises the bus requests the local side needs and answers snoops with a has-copy response, a data-supply strobe and a write-back request. Data storage, tags, arbitration and memory are outside it.

The Owned state lets a dirty line be read by other caches without writing it to memory first. A Modified line that sees a foreign read miss supplies its data and becomes Owned. The owner keeps answering later read misses. Memory is written only when the dirty line is evicted, or when a foreign write miss takes it away.

Local operations that need the bus wait in a single pending slot until the grant arrives, and only then commit. While a request waits, snoops may lower the line's state. The command on the bus always follows the line's current state.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped transaction sees no copy, and a local read requests the bus.
- R2: A local read (lreq_op = 0) of an Invalid line holds breq_valid with breq_cmd = 0 (read miss). In the cycle bus_gnt is high, lreq_done pulses and the line becomes Exclusive if bus_shared is low, otherwise Shared.
- R3: A local read of a Shared, Exclusive, Owned or Modified line completes in its accept cycle (lreq_done high) with no bus request and no state change.
- R4: A local write (lreq_op = 1) requests breq_cmd = 1 (write miss) for an Invalid line and breq_cmd = 2 (invalidate) for a Shared or Owned line, and enters Modified at the grant. For an Exclusive or Modified line it becomes Modified in the accept cycle with no bus request.
- R5: A pending bus request stays asserted with the same breq_idx until bus_gnt. The line does not take its new state before the grant. breq_cmd is derived from the line's present state, so a snoop that invalidates a Shared line turns a pending invalidate into a write miss.
- R6: A snooped read miss (snp_cmd = 0) moves Exclusive to Shared. It moves Modified to Owned and raises snp_supply. An Owned line stays Owned and raises snp_supply. Shared and Invalid lines are unchanged.
- R7: A snooped write miss (snp_cmd = 1) moves Shared, Exclusive, Owned and Modified lines to Invalid. For Owned and Modified lines it raises wb_req with wb_idx = snp_idx in the same cycle.
- R8: A snooped invalidate (snp_cmd = 2) moves Shared and Owned lines to Invalid. For an Exclusive or Modified line it raises snp_err and leaves the state unchanged.
- R9: A snooped write-update (snp_cmd = 3) moves Owned to Shared and leaves Invalid and Shared unchanged. For an Exclusive or Modified line it raises snp_err and leaves the state unchanged.
- R10: snp_shared is high in a snoop cycle exactly when the snooped line is not Invalid.
- R11: An eviction (lreq_op bit 1 set) completes in its accept cycle and makes the line Invalid. It raises wb_req with wb_idx = lreq_idx when the line was Owned or Modified, and does nothing else for Shared, Exclusive or Invalid lines.
- R12: lreq_ready is low while snp_valid is high and while a bus request is pending. A request offered while lreq_ready is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request offered |
| lreq_op | input | 2 | Bit 1: evict; otherwise bit 0: 1 write, 0 read |
| lreq_idx | input | IDX_W | Line addressed by the local request |
| lreq_ready | output | 1 | Local request can be taken this cycle |
| lreq_done | output | 1 | Local request committed this cycle |
| breq_valid | output | 1 | Bus transaction requested |
| breq_cmd | output | 2 | 0 read miss, 1 write miss, 2 invalidate |
| breq_idx | output | IDX_W | Line of the requested transaction |
| bus_gnt | input | 1 | Bus granted to the pending request |
| bus_shared | input | 1 | Another cache reported a copy (valid with bus_gnt) |
| snp_valid | input | 1 | Foreign transaction observed on the bus |
| snp_cmd | input | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write-update |
| snp_idx | input | IDX_W | Line of the observed transaction |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the line's data |
| snp_err | output | 1 | Snoop impossible for the line's state |
| wb_req | output | 1 | Write the line's dirty data to memory |
| wb_idx | output | IDX_W | Line to write back |

## Verification
The bench goes after the owner chain: Modified to Owned on a foreign read, and a second read that is still supplied. A design that drops the Owned state would stop supplying, or would write memory early. It also lets snoops lower a line while a local write waits for the grant. A design that latched the bus command at accept time would then send an invalidate for a line it no longer holds. Invalidates and write-updates sent to Exclusive or Modified lines must raise the error and keep the line, so a later silent write still completes in one cycle. Reads granted with and without bus_shared must end in Shared and Exclusive respectively, which shows up as a later write that either does or does not request the bus.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_O = 3'd3,
      ST_M = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      BC_RDMISS = 2'd0,
      BC_WRMISS = 2'd1,
      BC_INVAL  = 2'd2,
      BC_UPDATE = 2'd3
   } bus_cmd_e;

   function automatic logic st_dirty(line_st_e st);
      return (st == ST_M) || (st == ST_O);
   endfunction

endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array
   import moesi_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output line_st_e         rd_a_st,
   input  logic [IDX_W-1:0] rd_b_idx,
   output line_st_e         rd_b_st,
   input  logic             wa_en,
   input  logic [IDX_W-1:0] wa_idx,
   input  line_st_e         wa_st,
   input  logic             wb_en,
   input  logic [IDX_W-1:0] wb_idx,
   input  line_st_e         wb_st
);

   line_st_e lines [NUM_LINES];

   // One state register per line; port b (local commit) beats port a (snoop).
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      line_st_e st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q <= ST_I;
         else if (wb_en && (wb_idx == IDX_W'(g)))
            st_q <= wb_st;
         else if (wa_en && (wa_idx == IDX_W'(g)))
            st_q <= wa_st;
      end
      assign lines[g] = st_q;
   end

   assign rd_a_st = lines[rd_a_idx];
   assign rd_b_st = lines[rd_b_idx];

endmodule

// File: rtl/moesi_snoop_logic.sv
module moesi_snoop_logic
   import moesi_pkg::*;
(
   input  logic     snp_valid,
   input  bus_cmd_e snp_cmd,
   input  line_st_e cur_st,
   output logic     upd_en,
   output line_st_e nxt_st,
   output logic     has_copy,
   output logic     supply,
   output logic     flush,
   output logic     proto_err
);

   always_comb begin
      nxt_st    = cur_st;
      supply    = 1'b0;
      flush     = 1'b0;
      proto_err = 1'b0;
      if (snp_valid) begin
         unique case (snp_cmd)
            BC_RDMISS: begin
               if (cur_st == ST_E) nxt_st = ST_S;
               if (cur_st == ST_M) nxt_st = ST_O;
               supply = st_dirty(cur_st);
            end
            BC_WRMISS: begin
               nxt_st = ST_I;
               flush  = st_dirty(cur_st);
            end
            BC_INVAL: begin
               if (cur_st == ST_S || cur_st == ST_O) nxt_st = ST_I;
               proto_err = (cur_st == ST_E) || (cur_st == ST_M);
            end
            BC_UPDATE: begin
               if (cur_st == ST_O) nxt_st = ST_S;
               proto_err = (cur_st == ST_E) || (cur_st == ST_M);
            end
            default: ;
         endcase
      end
      upd_en   = snp_valid && (nxt_st != cur_st);
      has_copy = snp_valid && (cur_st != ST_I);
   end

endmodule

// File: rtl/moesi_local_ctrl.sv
module moesi_local_ctrl
   import moesi_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lreq_valid,
   input  logic [1:0]       lreq_op,
   input  logic [IDX_W-1:0] lreq_idx,
   input  logic             snp_valid,
   input  logic             bus_gnt,
   input  logic             bus_shared,
   input  line_st_e         cur_st,
   output logic [IDX_W-1:0] look_idx,
   output logic             lreq_ready,
   output logic             lreq_done,
   output logic             breq_valid,
   output bus_cmd_e         breq_cmd,
   output logic             wr_en,
   output line_st_e         wr_st,
   output logic             evict_wb
);

   logic             waiting;
   logic [IDX_W-1:0] pend_idx;
   logic             pend_wr;
   logic             accept, is_evict, is_write, need_bus;

   always_comb begin
      look_idx   = waiting ? pend_idx : lreq_idx;
      lreq_ready = !waiting && !snp_valid;
      accept     = lreq_valid && lreq_ready;
      is_evict   = lreq_op[1];
      is_write   = !lreq_op[1] && lreq_op[0];
      need_bus   = !is_evict && ((cur_st == ST_I) ||
                   (is_write && (cur_st == ST_S || cur_st == ST_O)));

      breq_valid = waiting;
      // Command follows the present line state: snoops may lower it while waiting.
      if (pend_wr)
         breq_cmd = (cur_st == ST_I) ? BC_WRMISS : BC_INVAL;
      else
         breq_cmd = BC_RDMISS;

      lreq_done = 1'b0;
      wr_en     = 1'b0;
      wr_st     = cur_st;
      evict_wb  = 1'b0;
      if (!waiting) begin
         if (accept && !need_bus) begin
            lreq_done = 1'b1;
            if (is_evict) begin
               wr_en    = 1'b1;
               wr_st    = ST_I;
               evict_wb = st_dirty(cur_st);
            end else if (is_write) begin
               wr_en = 1'b1;
               wr_st = ST_M;
            end
         end
      end else if (bus_gnt) begin
         lreq_done = 1'b1;
         wr_en     = 1'b1;
         wr_st     = pend_wr ? ST_M : (bus_shared ? ST_S : ST_E);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting  <= 1'b0;
         pend_idx <= '0;
         pend_wr  <= 1'b0;
      end else if (!waiting && accept && need_bus) begin
         waiting  <= 1'b1;
         pend_idx <= lreq_idx;
         pend_wr  <= is_write;
      end else if (waiting && bus_gnt) begin
         waiting <= 1'b0;
      end
   end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
   import moesi_pkg::*;
#(
   parameter  int NUM_LINES = 16,
   localparam int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lreq_valid,
   input  logic [1:0]       lreq_op,
   input  logic [IDX_W-1:0] lreq_idx,
   output logic             lreq_ready,
   output logic             lreq_done,
   output logic             breq_valid,
   output logic [1:0]       breq_cmd,
   output logic [IDX_W-1:0] breq_idx,
   input  logic             bus_gnt,
   input  logic             bus_shared,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [IDX_W-1:0] snp_idx,
   output logic             snp_shared,
   output logic             snp_supply,
   output logic             snp_err,
   output logic             wb_req,
   output logic [IDX_W-1:0] wb_idx
);

   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("moesi_line_ctrl: NUM_LINES must be a power of two, at least 2");
   end

   line_st_e         snp_st, loc_st, snp_nxt, loc_nxt;
   logic             snp_upd, snp_flush, loc_wr, evict_wb;
   logic [IDX_W-1:0] look_idx;
   bus_cmd_e         cmd_q;

   moesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (snp_idx),
      .rd_a_st  (snp_st),
      .rd_b_idx (look_idx),
      .rd_b_st  (loc_st),
      .wa_en    (snp_upd),
      .wa_idx   (snp_idx),
      .wa_st    (snp_nxt),
      .wb_en    (loc_wr),
      .wb_idx   (look_idx),
      .wb_st    (loc_nxt)
   );

   moesi_snoop_logic u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (bus_cmd_e'(snp_cmd)),
      .cur_st    (snp_st),
      .upd_en    (snp_upd),
      .nxt_st    (snp_nxt),
      .has_copy  (snp_shared),
      .supply    (snp_supply),
      .flush     (snp_flush),
      .proto_err (snp_err)
   );

   moesi_local_ctrl #(.IDX_W(IDX_W)) u_local (
      .clk        (clk),
      .rst_n      (rst_n),
      .lreq_valid (lreq_valid),
      .lreq_op    (lreq_op),
      .lreq_idx   (lreq_idx),
      .snp_valid  (snp_valid),
      .bus_gnt    (bus_gnt),
      .bus_shared (bus_shared),
      .cur_st     (loc_st),
      .look_idx   (look_idx),
      .lreq_ready (lreq_ready),
      .lreq_done  (lreq_done),
      .breq_valid (breq_valid),
      .breq_cmd   (cmd_q),
      .wr_en      (loc_wr),
      .wr_st      (loc_nxt),
      .evict_wb   (evict_wb)
   );

   assign breq_cmd = cmd_q;
   assign breq_idx = look_idx;
   // Snoop and local accept never share a cycle, so the two sources are exclusive.
   assign wb_req   = snp_flush || evict_wb;
   assign wb_idx   = snp_flush ? snp_idx : lreq_idx;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lreq_valid,
   input logic [1:0]       lreq_op,
   input logic             lreq_ready,
   input logic             lreq_done,
   input logic             breq_valid,
   input logic [IDX_W-1:0] breq_idx,
   input logic             bus_gnt,
   input logic             snp_valid,
   input logic [1:0]       snp_cmd,
   input logic             snp_shared,
   input logic             snp_supply,
   input logic             snp_err,
   input logic             wb_req
);

   assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (breq_valid && !bus_gnt) |=> (breq_valid && $stable(breq_idx)));

   assert_ready_snoop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid || breq_valid) |-> !lreq_ready);

   assert_supply_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_valid && snp_cmd == 2'd0 && snp_shared));

   // Covers R8 and R9: errors only for invalidate/update on a held line.
   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_err |-> (snp_valid && snp_cmd[1] && snp_shared));

   assert_wb_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> ((snp_valid && snp_cmd == 2'd1 && snp_shared) ||
                  (lreq_valid && lreq_ready && lreq_op[1])));

   assert_grant_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_done && breq_valid) |-> bus_gnt);

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lreq_valid (lreq_valid),
   .lreq_op    (lreq_op),
   .lreq_ready (lreq_ready),
   .lreq_done  (lreq_done),
   .breq_valid (breq_valid),
   .breq_idx   (breq_idx),
   .bus_gnt    (bus_gnt),
   .snp_valid  (snp_valid),
   .snp_cmd    (snp_cmd),
   .snp_shared (snp_shared),
   .snp_supply (snp_supply),
   .snp_err    (snp_err),
   .wb_req     (wb_req)
);

// File: tb/moesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb;

   localparam int NL = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lreq_valid = 1'b0;
   logic [1:0]    lreq_op = 2'd0;
   logic [IW-1:0] lreq_idx = '0;
   logic          lreq_ready, lreq_done, breq_valid;
   logic [1:0]    breq_cmd;
   logic [IW-1:0] breq_idx;
   logic          bus_gnt = 1'b0, bus_shared = 1'b0, snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [IW-1:0] snp_idx = '0;
   logic          snp_shared, snp_supply, snp_err, wb_req;
   logic [IW-1:0] wb_idx;

   always #2.5 clk = ~clk;

   moesi_line_ctrl #(.NUM_LINES(NL)) u_dut (.*);

   // Bench model: 0 I, 1 S, 2 E, 3 O, 4 M
   int mst [NL];
   bit mwait;
   int mpidx;
   bit mpwr;
   int n_chk = 0;
   int n_fail = 0;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit dirty(int s);
      return (s == 3) || (s == 4);
   endfunction

   task automatic drv(bit lv, logic [1:0] lop, int lidx, bit sv, logic [1:0] scmd,
                      int sidx, bit gnt, bit shd);
      int sst, snx, lst, pst, e_cmd, e_bidx;
      bit acc, need, e_done, e_bv, evwb, flush, e_ready;
      lreq_valid = lv; lreq_op = lop; lreq_idx = IW'(lidx);
      snp_valid = sv; snp_cmd = scmd; snp_idx = IW'(sidx);
      bus_gnt = gnt; bus_shared = shd;
      #1;
      sst = mst[sidx];
      snx = sst;
      if (sv) begin
         case (scmd)
            2'd0: begin if (sst == 2) snx = 1; if (sst == 4) snx = 3; end
            2'd1: snx = 0;
            2'd2: if (sst == 1 || sst == 3) snx = 0;
            default: if (sst == 3) snx = 1;
         endcase
      end
      flush   = sv && scmd == 2'd1 && dirty(sst);
      e_ready = !mwait && !sv;
      acc = 0; need = 0; evwb = 0; e_cmd = 0; e_bidx = 0;
      lst = mst[lidx];
      if (!mwait) begin
         acc    = lv && !sv;
         need   = !lop[1] && (lst == 0 || (lop[0] && (lst == 1 || lst == 3)));
         e_done = acc && !need;
         e_bv   = 0;
         evwb   = acc && lop[1] && dirty(lst);
      end else begin
         pst    = mst[mpidx];
         e_bv   = 1;
         e_cmd  = mpwr ? ((pst == 0) ? 1 : 2) : 0;
         e_bidx = mpidx;
         e_done = gnt;
      end
      check("R12 lreq_ready", int'(lreq_ready), int'(e_ready));
      check("R3/R11 lreq_done", int'(lreq_done), int'(e_done));
      check("R2/R4/R5 breq_valid", int'(breq_valid), int'(e_bv));
      if (e_bv) begin
         check("R2/R4/R5 breq_cmd", int'(breq_cmd), e_cmd);
         check("R5 breq_idx", int'(breq_idx), e_bidx);
      end
      check("R10/R1 snp_shared", int'(snp_shared), int'(sv && sst != 0));
      check("R6 snp_supply", int'(snp_supply), int'(sv && scmd == 2'd0 && dirty(sst)));
      check("R8/R9 snp_err", int'(snp_err),
            int'(sv && scmd[1] && (sst == 2 || sst == 4)));
      check("R7/R11 wb_req", int'(wb_req), int'(flush || evwb));
      if (flush || evwb)
         check("R7/R11 wb_idx", int'(wb_idx), flush ? sidx : lidx);
      // model update for the coming edge
      if (sv) mst[sidx] = snx;
      if (!mwait) begin
         if (acc) begin
            if (need) begin mwait = 1; mpidx = lidx; mpwr = lop[0]; end
            else if (lop[1]) mst[lidx] = 0;
            else if (lop[0]) mst[lidx] = 4;
         end
      end else if (gnt) begin
         mst[mpidx] = mpwr ? 4 : (shd ? 1 : 2);
         mwait = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      drv(0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      foreach (mst[i]) mst[i] = 0;
      mwait = 0; mpidx = 0; mpwr = 0;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: fresh lines report no copy; a read needs the bus
      drv(0, 2'd0, 0, 1, 2'd0, 5, 0, 0);
      drv(1, 2'd0, 0, 0, 2'd0, 0, 0, 0);
      idle();                                  // R5: still waiting
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 0);       // R2: grant, not shared -> E
      drv(1, 2'd1, 0, 0, 2'd0, 0, 0, 0);       // R4: E write silent -> M
      drv(0, 2'd0, 0, 1, 2'd0, 0, 0, 0);       // R6: M supplies -> O
      drv(0, 2'd0, 0, 1, 2'd0, 0, 0, 0);       // R6: O supplies, stays O
      drv(1, 2'd1, 0, 0, 2'd0, 0, 0, 0);       // R4: O write -> invalidate
      drv(0, 2'd0, 0, 1, 2'd3, 0, 0, 0);       // R9: update O -> S while waiting
      drv(0, 2'd0, 0, 1, 2'd1, 0, 0, 0);       // R7: write miss S -> I, no flush
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 0);       // R5: command now write miss; -> M
      drv(1, 2'd2, 0, 0, 2'd0, 0, 0, 0);       // R11: evict M -> write back
      drv(1, 2'd0, 0, 0, 2'd0, 0, 0, 0);       // R1/R2: line 0 Invalid again
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 0);
      drv(1, 2'd0, 1, 0, 2'd0, 0, 0, 0);       // R2: read line 1, shared -> S
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 1);
      drv(1, 2'd1, 1, 0, 2'd0, 0, 0, 0);       // R4: S write -> invalidate
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 0);
      drv(0, 2'd0, 0, 1, 2'd1, 1, 0, 0);       // R7: write miss on M flushes
      drv(1, 2'd0, 2, 0, 2'd0, 0, 0, 0);
      drv(0, 2'd0, 0, 0, 2'd0, 0, 1, 0);       // line 2 -> E
      drv(0, 2'd0, 0, 1, 2'd2, 2, 0, 0);       // R8: invalidate on E is error
      drv(0, 2'd0, 0, 1, 2'd3, 2, 0, 0);       // R9: update on E is error
      drv(1, 2'd0, 2, 0, 2'd0, 0, 0, 0);       // R3: read hit, no bus
      drv(1, 2'd1, 2, 0, 2'd0, 0, 0, 0);       // R8: still E, silent write
      drv(1, 2'd2, 2, 1, 2'd0, 3, 0, 0);       // R12: request during snoop not taken
      drv(1, 2'd2, 3, 0, 2'd0, 0, 0, 0);       // R11: evict Invalid is silent

      for (int i = 0; i < 4000; i++) begin
         bit g, s;
         g = mwait && ($urandom % 3 == 0);
         s = !g && ($urandom % 3 == 0);
         drv(bit'($urandom % 2), 2'($urandom % 4), int'($urandom % NL), s,
             2'($urandom % 4), int'($urandom % NL), g, bit'($urandom % 2));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule